// File: doc/BRIEF.md
# Boundary-Scan Test Port with Self-Test Launch

This block is a boundary-scan test access port run entirely from the test clock. A sixteen-state controller, steered by the mode input sampled on each rising test-clock edge, walks the standard data and instruction paths. A 4-bit instruction register selects one of three data paths between the serial input and the serial output. These paths are a 32-bit identification register, a single-bit pass-through register and a single-bit self-test result register.

The self-test instruction connects the block to an external built-in self-test engine through a start/done/fail handshake. After the instruction is loaded, the first rising edge spent in the idle state sends out a single start pulse. The engine later raises its done line with a fail flag. Both lines are synchronized into the test-clock domain, and the fail flag becomes the result bit (0 pass, 1 fail). The host reads that bit back with an ordinary data-register scan. The host is expected to keep the controller idling until the engine reports completion. Reset recycling after self-test is left to the system.

Top module: `jtag_selftest_tap`

## Requirements
- R1: While `trst_n` is low, and after it is released, the controller sits in Test-Logic-Reset, `tdo_en` is 0, `tdo` idles at 1, and the active instruction is the identification code 4'b0010.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, which reloads the identification instruction.
- R3: Capture-IR loads 4'b0001 into the 4-bit instruction shift stage. That stage is shifted least significant bit first from `tdi` to `tdo`, and the shifted code becomes active only at Update-IR.
- R4: Code 4'b0010 selects the identification register, 4'b0111 selects the self-test result register, and every other code, 4'b1111 included, selects the pass-through register.
- R5: Under the identification code, Capture-DR loads the 32-bit constant `ID_VALUE`, Shift-DR moves it out least significant bit first, and data shifted in never alters the value captured on the next scan.
- R6: Under the pass-through selection, Capture-DR loads 0 and Shift-DR gives a one-bit delay from `tdi` to `tdo`.
- R7: Update-IR with the self-test code preloads the result register with 1. That 1 is read back if no completion has yet been reported.
- R8: After the self-test code is updated, the first rising edge in Run-Test/Idle drives `bist_start` high for exactly one `tck` cycle. It does not pulse again until the code is loaded once more.
- R9: `bist_done` and `bist_fail` pass through a two-stage synchronizer. On a rising edge of the synchronized done while a test is running, the result bit takes the synchronized fail value (0 pass, 1 fail). It is read at the first `tdo` bit of a Shift-DR scan.
- R10: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only in Shift-DR and Shift-IR, and `tdo` is driven to 1 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low power-up reset, released synchronously |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while a shift state drives `tdo` |
| bist_start | output | 1 | One-cycle self-test launch pulse |
| bist_done | input | 1 | Self-test completion level from the engine (asynchronous) |
| bist_fail | input | 1 | Self-test failure flag, valid while `bist_done` is high |

## Verification
A wrong controller state shows up on the next falling edge as a `tdo_en` value that does not match the expected shift window, or as a scan of the wrong length. A wrong instruction decode is seen at the first data scan as a wrong captured prefix: the identification constant, a leading 0 or a leading 1. Faults in self-test sequencing appear either as a start pulse that is missing, repeated or one cycle late, seen the cycle after the first idle edge, or as a result bit that differs from the engine's fail flag once the synchronizer latency has elapsed.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] OP_RUNBIST = 4'b0111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS, PATH_IDENT, PATH_SELFTEST
  } dr_path_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_nxt;

  always_comb begin
    case (state)
      ST_RESET:  state_nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_nxt;
  end

  // Checker state: run length of consecutive high tms samples, saturating at 5.
  logic [2:0] ones_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ones_run <= 3'd0;
    else if (!tms)   ones_run <= 3'd0;
    else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
  end

  assert_five_ones_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_bit,
  output dr_path_e   path,
  output logic       arm_selftest
);

  logic [IR_W-1:0] ir_sh, ir_sh_nxt;
  logic [IR_W-1:0] ir_q, ir_q_nxt;

  always_comb begin
    ir_sh_nxt = ir_sh;
    if (state == ST_CAP_IR)     ir_sh_nxt = IR_CAPTURE;
    else if (state == ST_SH_IR) ir_sh_nxt = {tdi, ir_sh[IR_W-1:1]};
  end

  always_comb begin
    ir_q_nxt = ir_q;
    if (state == ST_RESET)       ir_q_nxt = OP_IDCODE;
    else if (state == ST_UPD_IR) ir_q_nxt = ir_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      ir_sh <= ir_sh_nxt;
      ir_q  <= ir_q_nxt;
    end
  end

  always_comb begin
    case (ir_q)
      OP_IDCODE:  path = PATH_IDENT;
      OP_RUNBIST: path = PATH_SELFTEST;
      default:    path = PATH_BYPASS;
    endcase
  end

  assign ir_bit       = ir_sh[0];
  assign arm_selftest = (state == ST_UPD_IR) && (ir_sh == OP_RUNBIST);

  assert_ir_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h2B7D_4093
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tap_state_e state,
  input  dr_path_e   path,
  input  logic       tdi,
  output logic       id_bit,
  output logic       byp_bit
);

  logic [ID_W-1:0] id_sh, id_sh_nxt;
  logic            byp_q, byp_nxt;
  logic            id_sel, byp_sel;

  assign id_sel  = (path == PATH_IDENT);
  assign byp_sel = (path == PATH_BYPASS);

  always_comb begin
    id_sh_nxt = id_sh;
    if (id_sel && state == ST_CAP_DR)     id_sh_nxt = ID_VALUE;
    else if (id_sel && state == ST_SH_DR) id_sh_nxt = {tdi, id_sh[ID_W-1:1]};
  end

  always_comb begin
    byp_nxt = byp_q;
    if (byp_sel && state == ST_CAP_DR)     byp_nxt = 1'b0;
    else if (byp_sel && state == ST_SH_DR) byp_nxt = tdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_sh <= ID_VALUE;
      byp_q <= 1'b0;
    end else begin
      id_sh <= id_sh_nxt;
      byp_q <= byp_nxt;
    end
  end

  assign id_bit  = id_sh[0];
  assign byp_bit = byp_q;

  assert_id_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_sel && state == ST_CAP_DR) |=> (id_sh == ID_VALUE));

  assert_bypass_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_sel && state == ST_CAP_DR) |=> (byp_q == 1'b0));

endmodule

// File: rtl/tap_selftest.sv
module tap_selftest
  import jtag_tap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       arm,
  input  logic       selected,
  input  logic       tdi,
  input  logic       done_async,
  input  logic       fail_async,
  output logic       result_bit,
  output logic       start
);

  logic [SYNC_STAGES:0]   done_sh;
  logic [SYNC_STAGES-1:0] fail_sh;
  logic armed, armed_nxt;
  logic running, running_nxt;
  logic result, result_nxt;
  logic start_nxt;
  logic done_edge, fail_s, fire;

  assign done_edge = done_sh[SYNC_STAGES-1] & ~done_sh[SYNC_STAGES];
  assign fail_s    = fail_sh[SYNC_STAGES-1];
  assign fire      = armed && (state == ST_IDLE);

  always_comb begin
    armed_nxt = armed;
    if (state == ST_RESET) armed_nxt = 1'b0;
    else if (arm)          armed_nxt = 1'b1;
    else if (fire)         armed_nxt = 1'b0;
  end

  always_comb begin
    running_nxt = running;
    if (fire)           running_nxt = 1'b1;
    else if (done_edge) running_nxt = 1'b0;
  end

  always_comb begin
    result_nxt = result;
    if (arm)                             result_nxt = 1'b1;
    else if (running && done_edge)       result_nxt = fail_s;
    else if (selected && state == ST_SH_DR) result_nxt = tdi;
  end

  assign start_nxt = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_sh <= '0;
      fail_sh <= '0;
      armed   <= 1'b0;
      running <= 1'b0;
      result  <= 1'b1;
      start   <= 1'b0;
    end else begin
      done_sh <= {done_sh[SYNC_STAGES-1:0], done_async};
      fail_sh <= {fail_sh[SYNC_STAGES-2:0], fail_async};
      armed   <= armed_nxt;
      running <= running_nxt;
      result  <= result_nxt;
      start   <= start_nxt;
    end
  end

  assign result_bit = result;

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_result_preload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> result);

endmodule

// File: rtl/jtag_selftest_tap.sv
module jtag_selftest_tap
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W        = 32,
  parameter logic [ID_W-1:0] ID_VALUE    = 32'h2B7D_4093,
  parameter int              SYNC_STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  output logic bist_start,
  input  logic bist_done,
  input  logic bist_fail
);

  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  tap_state_e state;
  dr_path_e   path;
  logic ir_bit, id_bit, byp_bit, st_bit, arm;

  tap_fsm u_fsm (.clk(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .clk(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .ir_bit(ir_bit), .path(path), .arm_selftest(arm)
  );

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .clk(tck), .rst_n(rst_n), .state(state), .path(path), .tdi(tdi),
    .id_bit(id_bit), .byp_bit(byp_bit)
  );

  tap_selftest #(.SYNC_STAGES(SYNC_STAGES)) u_st (
    .clk(tck), .rst_n(rst_n), .state(state), .arm(arm),
    .selected(path == PATH_SELFTEST), .tdi(tdi),
    .done_async(bist_done), .fail_async(bist_fail),
    .result_bit(st_bit), .start(bist_start)
  );

  logic out_mux, out_en;
  always_comb begin
    out_en = (state == ST_SH_DR) || (state == ST_SH_IR);
    if (state == ST_SH_IR)            out_mux = ir_bit;
    else if (path == PATH_IDENT)      out_mux = id_bit;
    else if (path == PATH_SELFTEST)   out_mux = st_bit;
    else                              out_mux = byp_bit;
  end

  logic tdo_q, tdo_en_q;
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q    <= 1'b1;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= out_mux;
      tdo_en_q <= out_en;
    end
  end

  assign tdo    = tdo_en_q ? tdo_q : 1'b1;
  assign tdo_en = tdo_en_q;

  assert_tdo_window_R10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR ||
                state == ST_EX1_DR || state == ST_EX1_IR));

endmodule

// File: tb/jtag_selftest_tap_test.sv
module jtag_selftest_tap_test;

  localparam logic [31:0] ID = 32'h2B7D_4093;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_en, bist_start;
  logic m_done = 1'b0;
  logic m_fail = 1'b0;
  logic want_fail = 1'b0;
  int   m_cnt = 0;
  int   starts = 0;
  int   errors = 0;
  int   checks = 0;

  always #5 tck = ~tck;

  jtag_selftest_tap uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_en(tdo_en), .bist_start(bist_start), .bist_done(m_done), .bist_fail(m_fail)
  );

  // Self-test engine model: drops done on start, reports after 20 cycles.
  always @(posedge tck) begin
    if (bist_start) begin
      m_done <= 1'b0;
      m_cnt  <= 20;
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) begin
        m_done <= 1'b1;
        m_fail <= want_fail;
      end
    end
  end

  always @(negedge tck) if (bist_start) starts++;

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  // From Select-DR: load an IR code, return to Select-DR; obs = captured IR bits.
  task automatic load_ir(input logic [3:0] code, output logic [3:0] obs);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge tck); #1;
      obs[i] = tdo;
      chk(tdo_en == 1'b1, "R10 tdo_en in Shift-IR", {39'd0, tdo_en}, 40'd1);
      step(i == 3, code[i]);
    end
    step(1, 0); step(1, 0);
  endtask

  // From Select-DR: scan n data bits, return to Select-DR.
  task automatic scan_dr(input int n, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(1, 0);
  endtask

  task automatic ones_to_reset();
    for (int i = 0; i < 5; i++) step(1, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [39:0] dout, exp;
    logic [3:0]  obs;
    // R1: reset state
    repeat (3) @(posedge tck);
    #1;
    chk(tdo_en == 1'b0 && tdo == 1'b1, "R1 reset outputs", {38'd0, tdo_en, tdo}, 40'd1);
    trst_n = 1'b1;
    repeat (3) step(1, 0);
    step(0, 0); step(1, 0);
    scan_dr(32, 40'h0, dout);
    chk(dout[31:0] == ID, "R1 R5 identification after reset", dout, {8'd0, ID});

    // R10: falling-edge timing, pass-through path
    load_ir(4'b1111, obs);
    step(0, 0); step(0, 0);
    @(negedge tck); #1;
    chk(tdo == 1'b0, "R6 bypass captures 0", {39'd0, tdo}, 40'd0);
    step(0, 1);
    chk(tdo == 1'b0, "R10 tdo holds after rising edge", {39'd0, tdo}, 40'd0);
    @(negedge tck); #1;
    chk(tdo == 1'b1, "R10 R6 tdo updates on falling edge", {39'd0, tdo}, 40'd1);
    step(1, 0);
    @(negedge tck); #1;
    chk(tdo_en == 1'b0 && tdo == 1'b1, "R10 idle outside shift", {38'd0, tdo_en, tdo}, 40'd1);
    step(1, 0); step(1, 0);

    // R3 R4 R5 R6 R7: sweep every instruction code
    for (int c = 0; c < 16; c++) begin
      logic [39:0] din;
      din = 40'hA5_3C96_0F1E ^ {36'd0, 4'(c)};
      load_ir(4'(c), obs);
      chk(obs == 4'b0001, "R3 IR capture pattern", {36'd0, obs}, 40'd1);
      scan_dr(34, din, dout);
      for (int i = 0; i < 34; i++) begin
        if (c == 2)      exp[i] = (i < 32) ? ID[i] : din[i-32];
        else if (c == 7) exp[i] = (i == 0) ? 1'b1 : din[i-1];
        else             exp[i] = (i == 0) ? 1'b0 : din[i-1];
      end
      exp[39:34] = '0;
      if (c == 2)      chk(dout == exp, "R4 R5 ident path", dout, exp);
      else if (c == 7) chk(dout == exp, "R4 R7 self-test path preload", dout, exp);
      else             chk(dout == exp, "R4 R6 pass-through path", dout, exp);
    end
    // R5: shifted-in data did not disturb the constant
    load_ir(4'b0010, obs);
    scan_dr(32, 40'hFF_FFFF_FFFF, dout);
    chk(dout[31:0] == ID, "R5 constant unaltered", dout, {8'd0, ID});

    // R2: five ones from many reachable states
    ones_to_reset();
    step(0, 0); step(1, 0);
    for (int p = 0; p < 64; p++) begin
      load_ir(4'b1111, obs);
      for (int i = 0; i < 6; i++) step(p[i], 0);
      ones_to_reset();
      #1;
      chk(tdo_en == 1'b0, "R2 reset reached", {39'd0, tdo_en}, 40'd0);
      step(0, 0); step(1, 0);
      scan_dr(32, 40'h0, dout);
      chk(dout[31:0] == ID, "R2 ident reloaded", dout, {8'd0, ID});
    end

    // R8 R9: self-test runs, pass then fail
    for (int f = 0; f < 2; f++) begin
      int s0;
      want_fail = f[0];
      load_ir(4'b0111, obs);
      s0 = starts;
      step(0, 0); step(1, 0); step(1, 0); step(0, 0);
      chk(bist_start == 1'b0, "R8 no start before idle edge", {39'd0, bist_start}, 40'd0);
      step(0, 0);
      chk(bist_start == 1'b1, "R8 start on first idle edge", {39'd0, bist_start}, 40'd1);
      step(0, 0);
      chk(bist_start == 1'b0, "R8 start lasts one cycle", {39'd0, bist_start}, 40'd0);
      step(1, 0);
      scan_dr(1, 40'h1, dout);
      chk(dout[0] == 1'b1, "R7 R9 result stays 1 before completion", dout, 40'd1);
      step(0, 0); step(1, 0); step(1, 0); step(0, 0);
      repeat (30) step(0, 0);
      chk(starts - s0 == 1, "R8 single start per load", 40'(starts - s0), 40'd1);
      step(1, 0);
      scan_dr(2, 40'h0, dout);
      chk(dout[0] == f[0], "R9 result equals fail flag", dout, 40'(f));
    end

    finish_run();
  end

endmodule